// File: doc/BRIEF.md
# Single-Digit Three-Base Logarithmic Multiply-Accumulate Cell

This cell takes one data digit and one coefficient digit, both held in a three-base logarithmic form. The bases are 2 and the two odd bases 3 and 5. The cell multiplies the two digits and adds the product to a running binary sum. Each digit is given as a sign, a zero marker, a signed exponent of base 2 and a signed exponent for each odd base. The multiplication adds the exponents base by base. The two odd-base sums together address a table that is built while the design is elaborated. The table returns the odd-base part of the product as a normalized mantissa with a binary exponent. The base-2 sum and that table exponent together set a single shift, which places the mantissa on the accumulator's binary point.

The accumulator is plain two's-complement binary and is never turned back into the logarithmic form. The cell receives a partial sum from its upstream neighbour and hands on a registered partial sum and a valid flag one cycle later. Because of this, cells can be placed in a row to form a feed-forward systolic 1D convolution.

Top module: `mdlns_mac_cell`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted input, acc_out is 0 and valid_out is 0.
- R2: The base-2 exponent of the product is d_exp2 + c_exp2. Both are 6-bit two's complement, and the sum is kept to 7 bits without loss.
- R3: For odd base 3 the exponent sum is a = d_expo[2:0] + c_expo[2:0], and for odd base 5 it is b = d_expo[5:3] + c_expo[5:3]. Each field is 3-bit two's complement and each sum is 4-bit two's complement. The table address is {b, a}, and the entry is m·2^e = 3^a·5^b. Here e = floor(log2(3^a·5^b)) and m is a 13-bit mantissa with 12 fraction bits, rounded to nearest.
- R4: The product magnitude, counted in accumulator units of 2^-8, is floor(m · 2^(e + p2 + 8 − 12)), where p2 is the base-2 sum. This value is clamped to 2^23 − 1.
- R5: The product is negative when d_sign XOR c_sign is 1. If d_zero or c_zero is 1, the product is 0 and acc_out equals acc_in one cycle later.
- R6: When valid_in is 1 and clr is 0, acc_out becomes acc_in + product at the next rising edge.
- R7: If the sum leaves the 24-bit signed range, acc_out saturates to 8388607 or to −8388608 and never wraps around.
- R8: valid_out equals valid_in of the previous cycle. When valid_in is 0 and clr is 0, acc_out keeps its value.
- R9: clr is synchronous and overrides valid_in. One cycle after clr, acc_out is 0 and valid_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the output register |
| valid_in | input | 1 | Input digits and acc_in are valid |
| d_sign | input | 1 | Data digit sign (1 = negative) |
| d_zero | input | 1 | Data digit is zero |
| d_exp2 | input | 6 | Data base-2 exponent, two's complement |
| d_expo | input | 6 | Data odd-base exponents: [2:0] base 3, [5:3] base 5 |
| c_sign | input | 1 | Coefficient digit sign |
| c_zero | input | 1 | Coefficient digit is zero |
| c_exp2 | input | 6 | Coefficient base-2 exponent |
| c_expo | input | 6 | Coefficient odd-base exponents, same layout |
| acc_in | input | 24 | Partial sum from the upstream cell, Q15.8 |
| valid_out | output | 1 | acc_out holds a freshly accumulated value |
| acc_out | output | 24 | Registered partial sum, Q15.8 |

## Verification
On every cycle the assertions check four things. Every table entry read out is normalized. Clear, hold and valid forwarding behave as specified. A zero digit passes acc_in through unchanged. An addition of two terms with the same sign never wraps. The numeric value of the product cannot be seen by a property: correct table rounding, shift direction, right-shift truncation and magnitude clamping appear only when the bench compares results with its own floating-point model. It does so across random exponents, a narrow range that avoids saturation, and directed extremes.

// File: rtl/mdlns_pkg.sv
`timescale 1ns/1ps
package mdlns_pkg;

  localparam int ODD_N = 2;

  typedef struct packed {
    logic signed [31:0] ex;
    logic [31:0]        mant;
  } rom_val_t;

  // Entry for table index idx: low sw bits are the exponent of base0,
  // next sw bits the exponent of base1, both two's complement.
  function automatic rom_val_t mdlns_rom_val(input int idx, input int sw,
                                             input int base0, input int base1,
                                             input int frac);
    int          span;
    int          x0;
    int          x1;
    int          e;
    int          sh;
    logic [127:0] num;
    logic [127:0] den;
    logic [127:0] n2;
    logic [127:0] d2;
    logic [127:0] q;
    rom_val_t     r;
    span = 1 << sw;
    x0 = idx % span;
    if (x0 >= span / 2) x0 = x0 - span;
    x1 = (idx / span) % span;
    if (x1 >= span / 2) x1 = x1 - span;
    num = 128'd1;
    den = 128'd1;
    for (int i = 0; i < ((x0 < 0) ? -x0 : x0); i++) begin
      if (x0 > 0) num = num * 128'(base0);
      else        den = den * 128'(base0);
    end
    for (int i = 0; i < ((x1 < 0) ? -x1 : x1); i++) begin
      if (x1 > 0) num = num * 128'(base1);
      else        den = den * 128'(base1);
    end
    e = 0;
    if (num >= den) begin
      while (num >= (den << (e + 1))) e = e + 1;
    end else begin
      while ((num << (-e)) < den) e = e - 1;
    end
    sh = frac - e;
    if (sh >= 0) begin
      n2 = num << sh;
      d2 = den;
    end else begin
      n2 = num;
      d2 = den << (-sh);
    end
    q = ((n2 << 1) + d2) / (d2 << 1);
    if (q == (128'd2 << frac)) begin
      q = q >> 1;
      e = e + 1;
    end
    r.mant = q[31:0];
    r.ex   = 32'(e);
    return r;
  endfunction

endpackage

// File: rtl/mdlns_exp_add.sv
`timescale 1ns/1ps
module mdlns_exp_add #(
  parameter int E2_W  = 6,
  parameter int ODD_W = 3,
  parameter int ODD_N = 2,
  localparam int SW   = ODD_W + 1
) (
  input  logic signed [E2_W-1:0]        d_e2,
  input  logic signed [E2_W-1:0]        c_e2,
  input  logic [ODD_N*ODD_W-1:0]        d_eo,
  input  logic [ODD_N*ODD_W-1:0]        c_eo,
  output logic signed [E2_W:0]          sum_e2,
  output logic [ODD_N*SW-1:0]           rom_addr
);

  assign sum_e2 = {d_e2[E2_W-1], d_e2} + {c_e2[E2_W-1], c_e2};

  for (genvar g = 0; g < ODD_N; g++) begin : g_odd
    logic [ODD_W-1:0] da;
    logic [ODD_W-1:0] ca;
    assign da = d_eo[g*ODD_W +: ODD_W];
    assign ca = c_eo[g*ODD_W +: ODD_W];
    assign rom_addr[g*SW +: SW] = {da[ODD_W-1], da} + {ca[ODD_W-1], ca};
  end

endmodule

// File: rtl/mdlns_rom.sv
`timescale 1ns/1ps
module mdlns_rom
  import mdlns_pkg::*;
#(
  parameter int ODD_W  = 3,
  parameter int BASE0  = 3,
  parameter int BASE1  = 5,
  parameter int MANT_F = 12,
  parameter int REXP_W = 7,
  localparam int SW    = ODD_W + 1,
  localparam int AW    = ODD_N * SW,
  localparam int DEPTH = 1 << AW
) (
  input  logic [AW-1:0]              addr,
  output logic [MANT_F:0]            mant,
  output logic signed [REXP_W-1:0]   rexp
);

  logic [MANT_F:0]   mant_tbl [DEPTH];
  logic [REXP_W-1:0] exp_tbl  [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam rom_val_t V = mdlns_rom_val(gi, SW, BASE0, BASE1, MANT_F);
    assign mant_tbl[gi] = V.mant[MANT_F:0];
    assign exp_tbl[gi]  = V.ex[REXP_W-1:0];
  end

  assign mant = mant_tbl[addr];
  assign rexp = $signed(exp_tbl[addr]);

  // R3: every entry read out carries its leading one
  always_comb begin
    a_r3_rom_normalized: assert (mant[MANT_F] == 1'b1);
  end

endmodule

// File: rtl/mdlns_align.sv
`timescale 1ns/1ps
module mdlns_align #(
  parameter int MANT_F   = 12,
  parameter int REXP_W   = 7,
  parameter int E2S_W    = 7,
  parameter int ACC_W    = 24,
  parameter int ACC_FRAC = 8,
  localparam int SH_W    = ((REXP_W > E2S_W) ? REXP_W : E2S_W) + 3,
  localparam int WIDE_W  = MANT_F + 1 + ACC_W
) (
  input  logic [MANT_F:0]            mant,
  input  logic signed [REXP_W-1:0]   rexp,
  input  logic signed [E2S_W-1:0]    sum_e2,
  input  logic                       neg,
  input  logic                       zero,
  output logic signed [ACC_W-1:0]    prod
);

  localparam logic [WIDE_W-1:0] PMAX_W = {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic [SH_W-1:0]   SH_SAT = SH_W'(ACC_W - 1);
  localparam logic signed [SH_W-1:0] SH_OFS = SH_W'(ACC_FRAC - MANT_F);

  logic signed [SH_W-1:0] sh;
  logic [SH_W-1:0]        sh_mag;
  logic [WIDE_W-1:0]      m_ext;
  logic [WIDE_W-1:0]      wide;
  logic [ACC_W-2:0]       mag;
  logic signed [ACC_W-1:0] pos_v;

  assign sh     = SH_W'(rexp) + SH_W'(sum_e2) + SH_OFS;
  assign sh_mag = sh[SH_W-1] ? SH_W'(-sh) : SH_W'(sh);
  assign m_ext  = WIDE_W'(mant);

  always_comb begin
    wide = '0;
    mag  = '0;
    if (zero) begin
      mag = '0;
    end else if (!sh[SH_W-1]) begin
      if (sh_mag >= SH_SAT) begin
        mag = '1;
      end else begin
        wide = m_ext << sh_mag;
        if (wide > PMAX_W) mag = '1;
        else               mag = wide[ACC_W-2:0];
      end
    end else begin
      wide = m_ext >> sh_mag;
      mag  = wide[ACC_W-2:0];
    end
  end

  assign pos_v = {1'b0, mag};
  assign prod  = neg ? -pos_v : pos_v;

endmodule

// File: rtl/mdlns_mac_cell.sv
`timescale 1ns/1ps
module mdlns_mac_cell
  import mdlns_pkg::*;
#(
  parameter int E2_W     = 6,
  parameter int ODD_W    = 3,
  parameter int BASE0    = 3,
  parameter int BASE1    = 5,
  parameter int MANT_F   = 12,
  parameter int REXP_W   = 7,
  parameter int ACC_W    = 24,
  parameter int ACC_FRAC = 8,
  localparam int SW      = ODD_W + 1,
  localparam int AW      = ODD_N * SW,
  localparam int OX_W    = ODD_N * ODD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    valid_in,
  input  logic                    d_sign,
  input  logic                    d_zero,
  input  logic [E2_W-1:0]         d_exp2,
  input  logic [OX_W-1:0]         d_expo,
  input  logic                    c_sign,
  input  logic                    c_zero,
  input  logic [E2_W-1:0]         c_exp2,
  input  logic [OX_W-1:0]         c_expo,
  input  logic [ACC_W-1:0]        acc_in,
  output logic                    valid_out,
  output logic [ACC_W-1:0]        acc_out
);

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [E2_W:0]        sum_e2;
  logic [AW-1:0]               rom_addr;
  logic [MANT_F:0]             mant;
  logic signed [REXP_W-1:0]    rexp;
  logic signed [ACC_W-1:0]     prod;
  logic                        prod_neg;
  logic                        prod_zero;
  logic signed [ACC_W:0]       sum_ext;
  logic [ACC_W-1:0]            sum_sat;
  logic                        acc_en;
  logic [ACC_W-1:0]            acc_d;
  logic                        vld_d;
  logic [ACC_W-1:0]            acc_q;
  logic                        vld_q;

  mdlns_exp_add #(.E2_W(E2_W), .ODD_W(ODD_W), .ODD_N(ODD_N)) u_exp_add (
    .d_e2     ($signed(d_exp2)),
    .c_e2     ($signed(c_exp2)),
    .d_eo     (d_expo),
    .c_eo     (c_expo),
    .sum_e2   (sum_e2),
    .rom_addr (rom_addr)
  );

  mdlns_rom #(.ODD_W(ODD_W), .BASE0(BASE0), .BASE1(BASE1),
              .MANT_F(MANT_F), .REXP_W(REXP_W)) u_rom (
    .addr (rom_addr),
    .mant (mant),
    .rexp (rexp)
  );

  assign prod_neg  = d_sign ^ c_sign;
  assign prod_zero = d_zero | c_zero;

  mdlns_align #(.MANT_F(MANT_F), .REXP_W(REXP_W), .E2S_W(E2_W + 1),
                .ACC_W(ACC_W), .ACC_FRAC(ACC_FRAC)) u_align (
    .mant   (mant),
    .rexp   (rexp),
    .sum_e2 (sum_e2),
    .neg    (prod_neg),
    .zero   (prod_zero),
    .prod   (prod)
  );

  // saturating accumulate
  always_comb begin
    sum_ext = $signed({acc_in[ACC_W-1], acc_in}) + $signed({prod[ACC_W-1], prod});
    if (sum_ext[ACC_W] != sum_ext[ACC_W-1]) sum_sat = sum_ext[ACC_W] ? ACC_MIN : ACC_MAX;
    else                                    sum_sat = sum_ext[ACC_W-1:0];
  end

  // next state
  always_comb begin
    acc_en = clr | valid_in;
    vld_d  = valid_in & ~clr;
    acc_d  = clr ? '0 : sum_sat;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign acc_out   = acc_q;
  assign valid_out = vld_q;

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_out == '0) && !valid_out);

  a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> valid_out == $past(valid_in));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !valid_in) |=> $stable(acc_out));

  a_r5_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clr && (d_zero || c_zero)) |=> acc_out == $past(acc_in));

  a_r7_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clr && !acc_in[ACC_W-1] && !prod[ACC_W-1]) |=> !acc_out[ACC_W-1]);

  a_r7_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clr && acc_in[ACC_W-1] && prod[ACC_W-1]) |=> acc_out[ACC_W-1]);

endmodule

// File: tb/test_mdlns_mac_cell.sv
`timescale 1ns/1ps
module test_mdlns_mac_cell;

  localparam longint PMAX = 64'd8388607;
  localparam longint AMIN = -64'sd8388608;

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        valid_in;
  logic        d_sign, d_zero, c_sign, c_zero;
  logic [5:0]  d_exp2, c_exp2, d_expo, c_expo;
  logic [23:0] acc_in;
  logic        valid_out;
  logic [23:0] acc_out;

  int checks;
  int fails;
  bit done;

  mdlns_mac_cell i_mdlns_mac_cell (
    .clk(clk), .rst_n(rst_n), .clr(clr), .valid_in(valid_in),
    .d_sign(d_sign), .d_zero(d_zero), .d_exp2(d_exp2), .d_expo(d_expo),
    .c_sign(c_sign), .c_zero(c_zero), .c_exp2(c_exp2), .c_expo(c_expo),
    .acc_in(acc_in), .valid_out(valid_out), .acc_out(acc_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic longint sx24(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  // Odd-base table value from floating point (R3)
  function automatic void ref_tbl(input int a, input int b, output longint m, output int e);
    real v;
    v = 1.0;
    for (int i = 0; i < ((a < 0) ? -a : a); i++) v = (a > 0) ? v * 3.0 : v / 3.0;
    for (int i = 0; i < ((b < 0) ? -b : b); i++) v = (b > 0) ? v * 5.0 : v / 5.0;
    e = 0;
    while (v >= 2.0) begin v = v / 2.0; e++; end
    while (v < 1.0)  begin v = v * 2.0; e--; end
    m = longint'($rtoi(v * 4096.0 + 0.5));
    if (m == 8192) begin m = 4096; e++; end
  endfunction

  // Signed product in units of 2^-8 (R2..R5)
  function automatic longint ref_prod(input bit ds, input bit dz, input int de2, input int de0,
                                      input int de1, input bit cs, input bit cz, input int ce2,
                                      input int ce0, input int ce1);
    longint m;
    longint mag;
    int e;
    int s;
    if (dz || cz) return 0;
    ref_tbl(de0 + ce0, de1 + ce1, m, e);
    s = e + de2 + ce2 + 8 - 12;
    if (s >= 23)      mag = PMAX;
    else if (s >= 0)  mag = m << s;
    else if (s > -40) mag = m >> (-s);
    else              mag = 0;
    if (mag > PMAX) mag = PMAX;
    return (ds ^ cs) ? -mag : mag;
  endfunction

  function automatic longint sat24(input longint v);
    if (v > PMAX) return PMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  task automatic check(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives, waits one cycle, checks.
  task automatic step(input bit v, input bit cl, input bit ds, input bit dz, input int de2,
                      input int de0, input int de1, input bit cs, input bit cz, input int ce2,
                      input int ce0, input int ce1, input longint ai, input string tag);
    longint exp_acc;
    bit     exp_vld;
    valid_in = v; clr = cl;
    d_sign = ds; d_zero = dz; d_exp2 = 6'(de2); d_expo = {3'(de1), 3'(de0)};
    c_sign = cs; c_zero = cz; c_exp2 = 6'(ce2); c_expo = {3'(ce1), 3'(ce0)};
    acc_in = 24'(ai);
    if (cl)     exp_acc = 0;
    else if (v) exp_acc = sat24(ai + ref_prod(ds, dz, de2, de0, de1, cs, cz, ce2, ce0, ce1));
    else        exp_acc = sx24(acc_out);
    exp_vld = v & ~cl;
    @(negedge clk);
    check(sx24(acc_out), exp_acc, {tag, " acc_out"});
    check(longint'(valid_out), longint'(exp_vld), {tag, " valid_out (R8)"});
  endtask

  initial begin
    int unsigned seed;
    longint ai;
    seed = $urandom(32'd7311);
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; clr = 1'b0; valid_in = 1'b0;
    d_sign = 0; d_zero = 0; c_sign = 0; c_zero = 0;
    d_exp2 = '0; c_exp2 = '0; d_expo = '0; c_expo = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    check(sx24(acc_out), 0, "R1 reset acc_out");
    check(longint'(valid_out), 0, "R1 reset valid_out");
    rst_n = 1'b1;
    @(negedge clk);
    check(sx24(acc_out), 0, "R1 after release acc_out");

    step(1,0, 0,0,0,0,0, 0,0,0,0,0, 0,       "R6 unity product");
    step(1,0, 0,0,3,0,0, 0,0,-1,0,0, 0,      "R2 base-2 sum");
    step(1,0, 0,0,0,1,0, 0,0,0,1,0, 0,       "R3 odd base 3 squared");
    step(1,0, 0,0,0,0,-2, 0,0,0,3,2, 5,      "R3 mixed odd exps");
    step(1,0, 0,0,0,-4,-4, 0,0,0,-4,-4, 100, "R4 right-shift underflow");
    step(1,0, 1,0,0,0,0, 0,0,0,0,0, 1000,    "R5 sign xor");
    step(1,0, 1,0,0,0,0, 1,0,0,0,0, -50,     "R5 both negative");
    step(1,0, 0,1,31,3,3, 0,0,31,3,3, 4321,  "R5 zero digit");
    step(1,0, 0,0,31,3,3, 1,0,31,3,3, 0,     "R4 magnitude clamp");
    step(1,0, 0,0,2,0,0, 0,0,0,0,0, 8388000, "R7 positive saturation");
    step(1,0, 0,0,2,0,0, 1,0,0,0,0, -8388000,"R7 negative saturation");
    step(1,0, 0,0,1,1,1, 0,0,1,0,0, 77,      "R6 load before hold");
    step(0,0, 0,0,5,2,2, 0,0,5,2,2, 999,     "R8 hold when not valid");
    step(1,1, 0,0,5,2,2, 0,0,5,2,2, 999,     "R9 clear overrides valid");
    step(1,0, 0,0,-32,-4,-4, 0,0,-32,-4,-4, -3, "R4 deep negative exponent");

    ai = 0;
    for (int i = 0; i < 600; i++) begin
      bit narrow;
      int de2, ce2;
      narrow = (i % 3) != 0;
      de2 = narrow ? int'($urandom_range(0, 15)) - 8 : int'($urandom_range(0, 63)) - 32;
      ce2 = narrow ? int'($urandom_range(0, 15)) - 8 : int'($urandom_range(0, 63)) - 32;
      if ($urandom_range(0, 3) == 0) ai = longint'($urandom_range(0, 32'hFFFFFF)) - 64'sd8388608;
      else                           ai = sx24(acc_out);
      step($urandom_range(0, 7) != 0, $urandom_range(0, 31) == 0,
           1'($urandom_range(0, 1)), $urandom_range(0, 15) == 0, de2,
           int'($urandom_range(0, 7)) - 4, int'($urandom_range(0, 7)) - 4,
           1'($urandom_range(0, 1)), $urandom_range(0, 15) == 0, ce2,
           int'($urandom_range(0, 7)) - 4, int'($urandom_range(0, 7)) - 4,
           ai, "R6 random accumulate");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule